// File: doc/BRIEF.md
# Field memory power-up sequencer

This block brings the write and read address pointers of a serial field memory to a known position after power-up. It follows a supply-stable input. Once that input has been high for a settling interval of about 100 microseconds, converted to system clock cycles from a clock-frequency parameter, it drives a run of dummy serial clock pulses on each side of the memory. It then drives a pointer-reset pulse on each side. The write side and the read side run at the same time, each with its own dummy count.

A recovery variant is selected by an input that is sampled when the sequence starts. It is meant for boards where dummy clocking may have begun before the supply settled. In that variant each side gets a reset pulse, then the dummy pulses, then a second reset pulse. When both sides have finished, the block raises `ready` and passes the normal datapath's serial clocks and resets straight through to the memory. A drop of the supply-stable input at any time sends the block back to the settling wait.

Top module: `fmem_init_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `ready` and all four memory-side outputs are 0, whatever the other inputs are.
- R2: The settling interval is SETTLE_CYC = ceil(CLK_HZ * SETTLE_US / 1e6) cycles. The first memory-side clock pulse on both sides goes high exactly SETTLE_CYC + SYNC_STAGES + 1 cycles after the first clock edge that samples `supply_ok` high.
- R3: During initialization every serial clock pulse is high for exactly one system cycle and then low for at least one system cycle.
- R4: With `recover_mode` = 0, the write side gives W_DUMMY pulses with `mem_wrst` = 0 followed by one pulse with `mem_wrst` = 1. The read side does the same with R_DUMMY pulses on `mem_rclk` and `mem_rrst`. Both sides start in the same cycle.
- R5: Every pointer-reset pulse goes high in the same cycle as the clock pulse it belongs to and stays high for exactly two system cycles, which is one full serial cycle.
- R6: With `recover_mode` = 1, each side gives one reset pulse, then its dummy pulses with reset low, then a second reset pulse.
- R7: `recover_mode` is sampled only in the cycle the sequence starts. Changing it later leaves the running sequence unchanged.
- R8: `ready` stays 0 until both sides have finished. It rises 2*Tmax + 1 cycles after the first clock pulse goes high, where T for a side is its dummy count + 1 (normal) or + 2 (recovery), and Tmax is the larger of the two sides' T.
- R9: While `ready` is 1, each memory-side output equals its datapath input in the same cycle. Before that, the datapath inputs have no effect on the memory side.
- R10: When `supply_ok` goes low, `ready` reads 0 from the third cycle on and the memory-side outputs are all 0 from then on. A later return of the supply runs the whole sequence again from the settling wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply-stable indication, asynchronous |
| recover_mode | input | 1 | 1 selects the reset–cycles–reset recovery sequence |
| dp_wclk | input | 1 | Datapath write serial clock |
| dp_wrst | input | 1 | Datapath write-pointer reset |
| dp_rclk | input | 1 | Datapath read serial clock |
| dp_rrst | input | 1 | Datapath read-pointer reset |
| mem_wclk | output | 1 | Write serial clock to the memory |
| mem_wrst | output | 1 | Write-pointer reset to the memory |
| mem_rclk | output | 1 | Read serial clock to the memory |
| mem_rrst | output | 1 | Read-pointer reset to the memory |
| ready | output | 1 | Initialization complete; datapath owns the memory pins |

## Verification
A fault in the settling counter shows up as the first memory clock pulse arriving early or late by a fixed number of cycles. A fault in a side engine's phase or pulse counter changes the number of plain pulses or reset pulses on that side, or the point where `ready` rises. A half-cycle error shows as a clock high for two samples or a reset pulse that is not two cycles long, visible within one serial cycle. A stuck output select shows as datapath values leaking onto the memory pins before `ready`, or not reaching them after. A missed supply drop shows as `ready` still high three cycles after the drop.

// File: rtl/fmem_init_pkg.sv
package fmem_init_pkg;

    typedef enum logic [1:0] {
        SQ_WAIT,
        SQ_SETTLE,
        SQ_RUN,
        SQ_READY
    } sq_state_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RST1,
        PH_DUMMY,
        PH_RST2,
        PH_DONE
    } side_phase_e;

    typedef struct packed {
        logic sclk;
        logic srst;
    } serial_ctl_t;

    localparam int SIDE_W    = 0;
    localparam int SIDE_R    = 1;
    localparam int NUM_SIDES = 2;

    // Settling cycles, rounded up: ceil(hz * us / 1e6)
    function automatic int settle_cycles(longint hz, longint us);
        longint prod;
        prod = hz * us;
        return int'((prod + 64'd999_999) / 64'd1_000_000);
    endfunction

    function automatic int cnt_width(int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/fmem_sync.sv
module fmem_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[STAGES-2:0], din};
        end
    end

    assign dout = shreg[STAGES-1];
endmodule

// File: rtl/fmem_settle_timer.sv
module fmem_settle_timer #(
    parameter int CYCLES = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    import fmem_init_pkg::*;

    localparam int CW = cnt_width(CYCLES);

    logic [CW-1:0] cnt;

    assign done = run && (cnt == CW'(CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (!done) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fmem_side_seq.sv
module fmem_side_seq #(
    parameter int DUMMY = 80
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       abort,
    input  logic                       start,
    input  logic                       recover,
    output fmem_init_pkg::serial_ctl_t ctl,
    output logic                       done
);
    import fmem_init_pkg::*;

    localparam int CW = cnt_width(DUMMY);

    side_phase_e   phase;
    logic          half;      // 0: clock-high phase, 1: clock-low phase
    logic [CW-1:0] cnt;
    logic          active;

    assign active = (phase == PH_RST1) || (phase == PH_DUMMY) || (phase == PH_RST2);

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            phase <= PH_IDLE;
            half  <= 1'b0;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= recover ? PH_RST1 : PH_DUMMY;
                        half  <= 1'b0;
                        cnt   <= '0;
                    end
                end
                PH_RST1, PH_DUMMY, PH_RST2: begin
                    half <= ~half;
                    if (half) begin
                        case (phase)
                            PH_RST1:  phase <= PH_DUMMY;
                            PH_DUMMY: begin
                                if (cnt == CW'(DUMMY - 1)) begin
                                    phase <= PH_RST2;
                                end else begin
                                    cnt <= cnt + 1'b1;
                                end
                            end
                            default:  phase <= PH_DONE;
                        endcase
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        ctl.sclk = active && !half;
        ctl.srst = (phase == PH_RST1) || (phase == PH_RST2);
    end

    assign done = (phase == PH_DONE);
endmodule

// File: rtl/fmem_init_seq.sv
module fmem_init_seq #(
    parameter longint CLK_HZ      = 125_000_000,
    parameter longint SETTLE_US   = 100,
    parameter int     W_DUMMY     = 80,
    parameter int     R_DUMMY     = 80,
    parameter int     SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    input  logic recover_mode,
    input  logic dp_wclk,
    input  logic dp_wrst,
    input  logic dp_rclk,
    input  logic dp_rrst,
    output logic mem_wclk,
    output logic mem_wrst,
    output logic mem_rclk,
    output logic mem_rrst,
    output logic ready
);
    import fmem_init_pkg::*;

    localparam int SETTLE_CYC = settle_cycles(CLK_HZ, SETTLE_US);

    sq_state_e             state, state_nx;
    logic                  supply_s;
    logic                  settle_done;
    logic                  seq_start;
    logic [NUM_SIDES-1:0]  side_done;
    serial_ctl_t           seq_ctl [NUM_SIDES];
    serial_ctl_t           dp_ctl  [NUM_SIDES];
    serial_ctl_t           out_ctl [NUM_SIDES];

    fmem_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (supply_ok),
        .dout (supply_s)
    );

    fmem_settle_timer #(.CYCLES(SETTLE_CYC)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (state == SQ_SETTLE),
        .done (settle_done)
    );

    assign seq_start = (state == SQ_SETTLE) && settle_done;

    always_comb begin
        state_nx = state;
        if (!supply_s) begin
            state_nx = SQ_WAIT;
        end else begin
            case (state)
                SQ_WAIT:   state_nx = SQ_SETTLE;
                SQ_SETTLE: if (settle_done) state_nx = SQ_RUN;
                SQ_RUN:    if (&side_done) state_nx = SQ_READY;
                default:   state_nx = SQ_READY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_WAIT;
        end else begin
            state <= state_nx;
        end
    end

    assign ready = (state == SQ_READY);

    assign dp_ctl[SIDE_W] = '{sclk: dp_wclk, srst: dp_wrst};
    assign dp_ctl[SIDE_R] = '{sclk: dp_rclk, srst: dp_rrst};

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        localparam int DCNT = (s == SIDE_W) ? W_DUMMY : R_DUMMY;

        fmem_side_seq #(.DUMMY(DCNT)) u_side (
            .clk     (clk),
            .rst     (rst),
            .abort   (!supply_s),
            .start   (seq_start),
            .recover (recover_mode),
            .ctl     (seq_ctl[s]),
            .done    (side_done[s])
        );

        assign out_ctl[s] = ready ? dp_ctl[s] : seq_ctl[s];
    end

    assign mem_wclk = out_ctl[SIDE_W].sclk;
    assign mem_wrst = out_ctl[SIDE_W].srst;
    assign mem_rclk = out_ctl[SIDE_R].sclk;
    assign mem_rrst = out_ctl[SIDE_R].srst;
endmodule

// File: rtl/fmem_init_chk.sv
module fmem_init_chk #(
    parameter int SETTLE_CYC  = 100,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_DUMMY   = 80
) (
    input logic clk,
    input logic rst,
    input logic supply_ok,
    input logic ready,
    input logic mem_wclk,
    input logic mem_wrst,
    input logic mem_rclk,
    input logic mem_rrst
);
    localparam int LIM = SETTLE_CYC + 2 * (MIN_DUMMY + 1) + SYNC_STAGES + 4;
    localparam int CW  = $clog2(LIM + 1);

    logic [CW-1:0] hi_run;   // consecutive cycles with supply_ok high

    always_ff @(posedge clk) begin
        if (rst || !supply_ok) begin
            hi_run <= '0;
        end else if (hi_run != CW'(LIM)) begin
            hi_run <= hi_run + 1'b1;
        end
    end

    // R2
    settle_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (!ready && $rose(mem_wclk) && int'(hi_run) >= SYNC_STAGES + 1)
        |-> int'(hi_run) >= SETTLE_CYC + SYNC_STAGES + 1);

    // R3
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        (!ready && !$past(ready) && ($past(mem_wclk) || $past(mem_rclk)))
        |-> !($past(mem_wclk) && mem_wclk) && !($past(mem_rclk) && mem_rclk));

    // R5
    rst_align_chk: assert property (@(posedge clk) disable iff (rst)
        (!ready && ($rose(mem_wrst) || $rose(mem_rrst)))
        |-> (!$rose(mem_wrst) || mem_wclk) && (!$rose(mem_rrst) || mem_rclk));

    // R8
    ready_late_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> int'(hi_run) >= SETTLE_CYC + 2 * (MIN_DUMMY + 1));

    // R10
    drop_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (!supply_ok && !$past(supply_ok) && !$past(supply_ok, 2) && !$past(supply_ok, 3))
        |-> !ready && !mem_wclk && !mem_wrst && !mem_rclk && !mem_rrst);
endmodule

bind fmem_init_seq fmem_init_chk #(
    .SETTLE_CYC  (SETTLE_CYC),
    .SYNC_STAGES (SYNC_STAGES),
    .MIN_DUMMY   ((W_DUMMY < R_DUMMY) ? W_DUMMY : R_DUMMY)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .supply_ok (supply_ok),
    .ready     (ready),
    .mem_wclk  (mem_wclk),
    .mem_wrst  (mem_wrst),
    .mem_rclk  (mem_rclk),
    .mem_rrst  (mem_rrst)
);

// File: tb/tb_fmem_init_seq.sv
module tb_fmem_init_seq;
    localparam longint CLK_HZ    = 1_000_000;
    localparam longint SETTLE_US = 100;
    localparam int     W_D       = 80;
    localparam int     R_D       = 83;
    localparam int     SYNC      = 2;
    localparam int     S_CYC     = int'((CLK_HZ * SETTLE_US + 999_999) / 1_000_000);
    localparam int     FIRST_EXP = S_CYC + SYNC + 1;
    localparam int     LIMIT     = 2000;

    // bit2: recover_mode, bit1: flip recover_mode mid-run, bit0: datapath inputs held high
    localparam logic [2:0] VEC [4] = '{3'b000, 3'b100, 3'b010, 3'b111};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic supply_ok = 1'b0, recover_mode = 1'b0;
    logic dp_wclk = 1'b0, dp_wrst = 1'b0, dp_rclk = 1'b0, dp_rrst = 1'b0;
    logic mem_wclk, mem_wrst, mem_rclk, mem_rrst, ready;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    fmem_init_seq #(
        .CLK_HZ(CLK_HZ), .SETTLE_US(SETTLE_US), .W_DUMMY(W_D), .R_DUMMY(R_D), .SYNC_STAGES(SYNC)
    ) dut (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .recover_mode(recover_mode),
        .dp_wclk(dp_wclk), .dp_wrst(dp_wrst), .dp_rclk(dp_rclk), .dp_rrst(dp_rrst),
        .mem_wclk(mem_wclk), .mem_wrst(mem_wrst), .mem_rclk(mem_rclk), .mem_rrst(mem_rrst),
        .ready(ready)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int mem_bus();
        return int'({ready, mem_wclk, mem_wrst, mem_rclk, mem_rrst});
    endfunction

    task automatic set_dp(input logic [3:0] v);
        {dp_wclk, dp_wrst, dp_rclk, dp_rrst} = v;
    endtask

    task automatic run_seq(input bit rec, input bit flip, input bit noise);
        int  first [2];
        int  lead [2];
        int  dum [2];
        int  tail [2];
        int  bad [2];
        int  rlen [2];
        bit  pc [2];
        bit  pr [2];
        bit  c [2];
        bit  r [2];
        int  ready_at;
        int  tmax;
        string tg;
        tg = rec ? "R6" : "R4";
        for (int s = 0; s < 2; s++) begin
            first[s] = -1; lead[s] = 0; dum[s] = 0; tail[s] = 0; bad[s] = 0; rlen[s] = 0;
            pc[s] = 1'b0; pr[s] = 1'b0;
        end
        ready_at = -1;
        @(negedge clk);
        supply_ok = 1'b0;
        repeat (6) @(negedge clk);
        recover_mode = rec;
        set_dp(noise ? 4'b1111 : 4'b0000);
        supply_ok = 1'b1;
        for (int i = 1; i <= LIMIT; i++) begin
            @(negedge clk);
            if (ready) begin
                ready_at = i;
                break;
            end
            c[0] = mem_wclk; r[0] = mem_wrst; c[1] = mem_rclk; r[1] = mem_rrst;
            for (int s = 0; s < 2; s++) begin
                if (c[s] && !pc[s]) begin
                    if (first[s] < 0) first[s] = i;
                    if (r[s]) begin
                        if (dum[s] == 0) lead[s]++;
                        else tail[s]++;
                    end else begin
                        dum[s]++;
                        if (tail[s] > 0) bad[s]++;
                    end
                end
                if (c[s] && pc[s]) bad[s]++;
                if (r[s] && !pr[s] && !c[s]) bad[s]++;
                if (r[s]) rlen[s]++;
                else if (pr[s]) begin
                    if (rlen[s] != 2) bad[s]++;
                    rlen[s] = 0;
                end
                pc[s] = c[s]; pr[s] = r[s];
            end
            if (flip && i == FIRST_EXP + 20) recover_mode = ~rec;
        end
        tmax = ((W_D > R_D) ? W_D : R_D) + 1 + int'(rec);
        chk("R2", "first write pulse sample", first[0], FIRST_EXP);
        chk("R2", "first read pulse sample", first[1], FIRST_EXP);
        chk(tg, "write dummy pulses", dum[0], W_D);
        chk(tg, "read dummy pulses", dum[1], R_D);
        chk(tg, "write trailing reset pulses", tail[0], 1);
        chk(tg, "read trailing reset pulses", tail[1], 1);
        chk(tg, "write leading reset pulses", lead[0], int'(rec));
        chk(tg, "read leading reset pulses", lead[1], int'(rec));
        chk("R3_R5", "write shape errors", bad[0], 0);
        chk("R3_R5", "read shape errors", bad[1], 0);
        chk("R8", "ready sample", ready_at, FIRST_EXP + 2 * tmax + 1);
        if (flip) chk("R7", "sequence unchanged after late mode flip", lead[0] + tail[0], int'(rec) + 1);
        if (noise) chk("R9", "datapath noise ignored before ready (write dummies)", dum[0], W_D);
        set_dp(4'b0000);
        recover_mode = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state with supply high and datapath inputs high
        rst = 1'b1;
        supply_ok = 1'b1;
        set_dp(4'b1111);
        repeat (4) @(negedge clk);
        chk("R1", "outputs in reset", mem_bus(), 0);
        rst = 1'b0;
        supply_ok = 1'b0;
        @(negedge clk);
        chk("R1", "outputs after reset release", mem_bus(), 0);
        set_dp(4'b0000);

        for (int v = 0; v < 4; v++) begin
            run_seq(VEC[v][2], VEC[v][1], VEC[v][0]);
        end

        // R9: pass-through once ready
        @(negedge clk);
        set_dp(4'b1010);
        #1 chk("R9", "pass-through 1010", mem_bus(), 5'b11010);
        @(negedge clk);
        set_dp(4'b0101);
        #1 chk("R9", "pass-through 0101", mem_bus(), 5'b10101);
        set_dp(4'b1111);

        // R10: supply drop while ready
        @(negedge clk);
        supply_ok = 1'b0;
        @(negedge clk);
        chk("R10", "ready one cycle after drop", int'(ready), 1);
        @(negedge clk);
        chk("R10", "ready two cycles after drop", int'(ready), 1);
        @(negedge clk);
        chk("R10", "outputs three cycles after drop", mem_bus(), 0);

        // R10: supply drop in the middle of the sequence, then full rerun
        set_dp(4'b0000);
        supply_ok = 1'b1;
        repeat (FIRST_EXP + 50) @(negedge clk);
        supply_ok = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10", "outputs after mid-run drop", mem_bus(), 0);
        repeat (10) @(negedge clk);
        chk("R10", "outputs stay quiet while supply low", mem_bus(), 0);
        run_seq(1'b0, 1'b0, 1'b0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule